// File: doc/BRIEF.md
# Instruction Fetch Page Pretranslator

This block sits in front of the instruction TLB and keeps one remembered pair: the virtual page of the last translated fetch and the physical frame it maps to. Fetch addresses are mostly sequential, so each new fetch PC is compared against the remembered page. When the pages match, the physical fetch address is formed directly from the remembered frame and the PC's page offset, and the TLB is not searched at all. When they differ, or nothing is remembered, the block raises a translation request toward the TLB. It waits for the reply, delivers the translated address and replaces the remembered pair with the new one.

The remembered pair must never outlive the TLB entry it copies. The TLB reports every entry it replaces or shoots down on an invalidate port, with an optional invalidate-all flag. Any invalidate that covers the remembered page clears the pair. While a TLB request is outstanding, the block drops its ready output, so the fetch unit holds its next address until the reply has been consumed.

Top module: `ifetch_page_pretrans`

## Requirements
- R1: After reset `xlat_valid_o` and `tlb_req_o` are low, `fetch_ready_o` is high, and the remembered pair is empty, so the first fetch always goes to the TLB.
- R2: An accepted fetch that finds no remembered page drives `tlb_req_o` high in the next cycle, with `tlb_req_vpn_o` equal to PC bits [31:12].
- R3: An accepted fetch whose PC bits [31:12] equal the remembered page gives `xlat_valid_o`=1 and `xlat_hit_o`=1 in the next cycle, and `tlb_req_o` stays low.
- R4: A fetch to a different page requests the TLB. The request and its page number hold until `tlb_rsp_valid_i`. In the cycle after the reply the block gives `xlat_valid_o`=1 with `xlat_hit_o`=0, and installs the reply, so a later fetch to the same page hits.
- R5: An invalidate whose page equals the remembered page clears the pair, so the next fetch to that page misses. An invalidate of another page leaves the pair intact.
- R6: An invalidate with `tlb_inv_all_i`=1 clears the pair whatever its page.
- R7: While a request is outstanding, `fetch_ready_o` is low and `fetch_valid_i` is ignored. No output is produced for a fetch presented during that time.
- R8: The physical address is the frame number in bits [31:12] followed by PC bits [11:0].
- R9: An invalidate covering the requested page in the same cycle as the reply still delivers the reply, but does not install it.
- R10: A reply arriving while no request is outstanding produces no output and does not change the remembered pair.
- R11: An invalidate covering the remembered page in the same cycle as a fetch to that page turns the fetch into a TLB request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | Fetch PC presented |
| fetch_pc_i | input | VA_W | Virtual fetch address |
| fetch_ready_o | output | 1 | Block can accept a fetch this cycle |
| xlat_valid_o | output | 1 | Physical fetch address valid (one cycle) |
| xlat_paddr_o | output | PA_W | Physical fetch address |
| xlat_hit_o | output | 1 | Address came from the remembered pair without a TLB search |
| tlb_req_o | output | 1 | Translation request to the TLB, held until reply |
| tlb_req_vpn_o | output | VA_W-PG_BITS | Virtual page to translate |
| tlb_rsp_valid_i | input | 1 | TLB reply valid |
| tlb_rsp_pfn_i | input | PA_W-PG_BITS | Physical frame returned by the TLB |
| tlb_inv_valid_i | input | 1 | TLB entry replaced or shot down |
| tlb_inv_all_i | input | 1 | Invalidate covers every page |
| tlb_inv_vpn_i | input | VA_W-PG_BITS | Virtual page being invalidated |

## Verification
The assertions assume that the TLB model answers each request with exactly one single-cycle reply, and that the fetch unit stops presenting a PC once it has been accepted. The bench drives a fetch for one cycle only while ready is high, except in the stall test, where it holds the fetch on purpose. Its TLB model pulses the reply once per observed request after a chosen latency. The idle-reply test pulses a reply with no request outstanding, which is the single case where the first assumption is lifted on purpose and which R10 covers.

// File: rtl/ifetch_page_pretrans.sv
module ifetch_page_pretrans #(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PG_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fetch_valid_i,
  input  logic [VA_W-1:0]         fetch_pc_i,
  output logic                    fetch_ready_o,
  output logic                    xlat_valid_o,
  output logic [PA_W-1:0]         xlat_paddr_o,
  output logic                    xlat_hit_o,
  output logic                    tlb_req_o,
  output logic [VA_W-PG_BITS-1:0] tlb_req_vpn_o,
  input  logic                    tlb_rsp_valid_i,
  input  logic [PA_W-PG_BITS-1:0] tlb_rsp_pfn_i,
  input  logic                    tlb_inv_valid_i,
  input  logic                    tlb_inv_all_i,
  input  logic [VA_W-PG_BITS-1:0] tlb_inv_vpn_i
);
  localparam int VPN_W = VA_W - PG_BITS;
  localparam int PFN_W = PA_W - PG_BITS;

  logic               pred_valid_q;
  logic [VPN_W-1:0]   pred_vpn_q;
  logic [PFN_W-1:0]   pred_pfn_q;
  logic               busy_q;
  logic [VPN_W-1:0]   pend_vpn_q;
  logic [PG_BITS-1:0] pend_ofs_q;
  logic               out_valid_q;
  logic               out_hit_q;
  logic [PA_W-1:0]    out_paddr_q;

  wire [VPN_W-1:0]   pc_vpn   = fetch_pc_i[VA_W-1:PG_BITS];
  wire [PG_BITS-1:0] pc_ofs   = fetch_pc_i[PG_BITS-1:0];
  wire               fire     = fetch_valid_i && !busy_q;
  wire               inv_pred = tlb_inv_valid_i && (tlb_inv_all_i || tlb_inv_vpn_i == pred_vpn_q);
  wire               inv_pend = tlb_inv_valid_i && (tlb_inv_all_i || tlb_inv_vpn_i == pend_vpn_q);
  wire               pred_hit = pred_valid_q && !inv_pred && (pc_vpn == pred_vpn_q);
  wire               rsp_take = busy_q && tlb_rsp_valid_i;

  assign fetch_ready_o = !busy_q;
  assign tlb_req_o     = busy_q;
  assign tlb_req_vpn_o = pend_vpn_q;
  assign xlat_valid_o  = out_valid_q;
  assign xlat_hit_o    = out_hit_q;
  assign xlat_paddr_o  = out_paddr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_hit_q   <= 1'b0;
      out_paddr_q <= '0;
    end else begin
      out_valid_q <= (fire && pred_hit) || rsp_take;
      if (fire && pred_hit) begin
        out_hit_q   <= 1'b1;
        out_paddr_q <= {pred_pfn_q, pc_ofs};
      end else if (rsp_take) begin
        out_hit_q   <= 1'b0;
        out_paddr_q <= {tlb_rsp_pfn_i, pend_ofs_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      pend_vpn_q <= '0;
      pend_ofs_q <= '0;
    end else if (fire && !pred_hit) begin
      busy_q     <= 1'b1;
      pend_vpn_q <= pc_vpn;
      pend_ofs_q <= pc_ofs;
    end else if (rsp_take) begin
      busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pred_valid_q <= 1'b0;
      pred_vpn_q   <= '0;
      pred_pfn_q   <= '0;
    end else if (rsp_take) begin
      pred_valid_q <= !inv_pend;
      pred_vpn_q   <= pend_vpn_q;
      pred_pfn_q   <= tlb_rsp_pfn_i;
    end else if (inv_pred) begin
      pred_valid_q <= 1'b0;
    end
  end

  p_hit_no_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_i && fetch_ready_o && pred_hit |=> xlat_valid_o && xlat_hit_o && !tlb_req_o);

  p_hit_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid_i && fetch_ready_o && pred_hit |=> xlat_paddr_o[PG_BITS-1:0] == $past(fetch_pc_i[PG_BITS-1:0]));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_o && !tlb_rsp_valid_i |=> tlb_req_o && $stable(tlb_req_vpn_o));

  p_rsp_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_o && tlb_rsp_valid_i |=> xlat_valid_o && !xlat_hit_o && xlat_paddr_o[PA_W-1:PG_BITS] == $past(tlb_rsp_pfn_i));

  p_no_hit_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req_o |=> !(xlat_valid_o && xlat_hit_o));

  p_inv_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_inv_valid_i && tlb_inv_all_i |=> !pred_valid_q);

  p_idle_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !tlb_req_o && !fetch_valid_i && tlb_rsp_valid_i |=> !xlat_valid_o);
endmodule

// File: tb/ifetch_page_pretrans_tb_top.sv
module ifetch_page_pretrans_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // bit 32: expected hit, bits 31:0: fetch PC
  localparam logic [32:0] VEC [NVEC] = '{
    33'h0_0040_1000, 33'h1_0040_1FFC, 33'h0_0040_2000, 33'h1_0040_2008,
    33'h0_0040_1010, 33'h1_0040_1ABC, 33'h0_7FFF_0000, 33'h1_7FFF_0FFF
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fv = 1'b0;
  logic [31:0] pc = '0;
  logic        rsp_v = 1'b0;
  logic [19:0] rsp_pfn = '0;
  logic        inv_v = 1'b0;
  logic        inv_all = 1'b0;
  logic [19:0] inv_vpn = '0;
  logic        ready, xv, xhit, req;
  logic [31:0] paddr;
  logic [19:0] req_vpn;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ifetch_page_pretrans dut_i (
    .clk(clk), .rst_n(rst_n), .fetch_valid_i(fv), .fetch_pc_i(pc), .fetch_ready_o(ready),
    .xlat_valid_o(xv), .xlat_paddr_o(paddr), .xlat_hit_o(xhit), .tlb_req_o(req),
    .tlb_req_vpn_o(req_vpn), .tlb_rsp_valid_i(rsp_v), .tlb_rsp_pfn_i(rsp_pfn),
    .tlb_inv_valid_i(inv_v), .tlb_inv_all_i(inv_all), .tlb_inv_vpn_i(inv_vpn)
  );

  function automatic logic [19:0] pfn_of(input logic [19:0] vpn);
    return vpn * 20'd3 + 20'h12345;
  endfunction

  function automatic logic [31:0] pa_of(input logic [31:0] va);
    return {pfn_of(va[31:12]), va[11:0]};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic expect_hit(input logic [31:0] a, input string tag);
    @(negedge clk); fv = 1'b1; pc = a;
    @(negedge clk); fv = 1'b0;
    chk(xv && xhit, {tag, " R3 hit valid"}, {xv, xhit}, 2'b11);
    chk(paddr == pa_of(a), {tag, " R8 hit paddr"}, paddr, pa_of(a));
    chk(!req, {tag, " R3 no tlb request"}, req, 0);
  endtask

  task automatic finish_miss(input logic [31:0] a, input int lat, input bit inv_same, input string tag);
    chk(req && req_vpn == a[31:12], {tag, " R2 request page"}, {req, req_vpn}, {1'b1, a[31:12]});
    chk(!xv && !ready, {tag, " R7 stalled"}, {xv, ready}, 0);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk(req && req_vpn == a[31:12], {tag, " R4 request held"}, {req, req_vpn}, {1'b1, a[31:12]});
    end
    rsp_v = 1'b1; rsp_pfn = pfn_of(a[31:12]);
    if (inv_same) begin inv_v = 1'b1; inv_all = 1'b0; inv_vpn = a[31:12]; end
    @(negedge clk); rsp_v = 1'b0; inv_v = 1'b0;
    chk(xv && !xhit, {tag, " R4 reply output"}, {xv, xhit}, 2'b10);
    chk(paddr == pa_of(a), {tag, " R8 reply paddr"}, paddr, pa_of(a));
    chk(ready && !req, {tag, " R4 request released"}, {ready, req}, 2'b10);
  endtask

  task automatic expect_miss(input logic [31:0] a, input int lat, input bit inv_same, input string tag);
    @(negedge clk); fv = 1'b1; pc = a;
    @(negedge clk); fv = 1'b0;
    finish_miss(a, lat, inv_same, tag);
  endtask

  task automatic pulse_inv(input bit all, input logic [19:0] vpn);
    @(negedge clk); inv_v = 1'b1; inv_all = all; inv_vpn = vpn;
    @(negedge clk); inv_v = 1'b0; inv_all = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!xv && !req && ready, "R1 reset outputs", {xv, req, ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!xv && !req && ready, "R1 idle after reset", {xv, req, ready}, 3'b001);

    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][32]) expect_hit(VEC[v][31:0], $sformatf("vec%0d", v));
      else expect_miss(VEC[v][31:0], v % 3, 1'b0, $sformatf("vec%0d", v));
    end

    // R5: non-matching invalidate keeps the pair, matching one clears it
    pulse_inv(1'b0, 20'h12345);
    expect_hit(32'h7FFF_0004, "R5 other page kept");
    pulse_inv(1'b0, 20'h7FFF0);
    expect_miss(32'h7FFF_0008, 1, 1'b0, "R5 matching cleared");

    // R6: invalidate-all
    pulse_inv(1'b1, 20'h00000);
    expect_miss(32'h7FFF_0010, 0, 1'b0, "R6 all cleared");
    expect_hit(32'h7FFF_0020, "R6 reinstalled");

    // R10: reply while idle is ignored
    @(negedge clk); rsp_v = 1'b1; rsp_pfn = 20'hABCDE;
    @(negedge clk); rsp_v = 1'b0;
    chk(!xv, "R10 idle reply no output", xv, 0);
    expect_hit(32'h7FFF_0030, "R10 pair unchanged");

    // R7: fetch held during outstanding request is ignored
    @(negedge clk); fv = 1'b1; pc = 32'h0060_0040;
    @(negedge clk); pc = 32'h7FFF_0050;
    chk(!ready && req, "R7 ready low", {ready, req}, 2'b01);
    @(negedge clk);
    chk(!xv, "R7 held fetch ignored", xv, 0);
    rsp_v = 1'b1; rsp_pfn = pfn_of(20'h00600);
    @(negedge clk); rsp_v = 1'b0; fv = 1'b0;
    chk(xv && !xhit && paddr == pa_of(32'h0060_0040), "R7 pending reply delivered", paddr, pa_of(32'h0060_0040));
    @(negedge clk);
    chk(!xv && !req, "R7 no output for ignored fetch", {xv, req}, 0);

    // R9: invalidate with reply blocks install
    expect_miss(32'h0050_0000, 2, 1'b1, "R9 reply with invalidate");
    expect_miss(32'h0050_0100, 1, 1'b0, "R9 not installed");
    expect_hit(32'h0050_0200, "R9 later install");

    // R11: invalidate in same cycle as fetch to stored page
    @(negedge clk); fv = 1'b1; pc = 32'h0050_0300; inv_v = 1'b1; inv_vpn = 20'h00500;
    @(negedge clk); fv = 1'b0; inv_v = 1'b0;
    chk(!xv, "R11 no hit output", xv, 0);
    finish_miss(32'h0050_0300, 1, 1'b0, "R11 turned to miss");

    // R1: reset mid-operation empties the pair
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(!xv && !req && ready, "R1 reset again", {xv, req, ready}, 3'b001);
    rst_n = 1'b1;
    expect_miss(32'h0050_0400, 0, 1'b0, "R1 first fetch misses");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule